// File: doc/BRIEF.md
# Automatic Channel Sequencer

This block walks a programmable set of measurement channels. It takes each enabled channel in turn and drives that channel's address to an external analog multiplexer. It then waits a settling time chosen for that channel, asks an external converter for a conversion, and accepts the 12-bit result when the converter reports completion. Each result either goes straight into the channel's 16-bit status register, or it is added to a per-channel accumulator. An accumulating channel writes its status register once per averaging window.

A one-cycle pulse marks every completed conversion. A second pulse marks the conversion that closes a pass over the enabled set. A 2-bit mode value selects halt, a single pass, continuous running, or continuous running with a fixed averaging window. Writing the mode always restarts the walk from the lowest enabled channel. The status registers are read through a simple combinational read port.

Top module: `chan_sequencer`

## Requirements
- R1: Enabled channels are visited in ascending index order, wrapping from the highest enabled channel to the lowest. Each conversion request (`conv_start`) is a single-cycle pulse.
- R2: After a conversion completes, exactly 4 cycles pass before the next request. The count is 10 cycles when the next channel's bit in `settle_ext` is 1.
- R3: `mux_addr` carries the channel index, zero-extended, and holds steady from the settling phase through the request cycle.
- R4: For a channel whose `avg_en` bit is 0, each completed conversion writes the status register with the result in bits 15:4 and zeros in bits 3:0. This happens on every pass.
- R5: A channel whose `avg_en` bit is 1 writes its status register only on the last pass of an averaging window. The value written is the sum of the window's samples shifted right by log2 of the window size. `avg_sel` 0, 1, 2 and 3 select windows of 1, 16, 64 and 256 samples.
- R6: In mode 3, the averaging window is 16 samples whatever `avg_sel` holds.
- R7: `eoc` pulses for one cycle, in the cycle after `conv_done`, once per completed conversion. The updated status is readable in that same cycle.
- R8: `eos` pulses together with the `eoc` of the highest enabled channel.
- R9: A mode write (`mode_wr`) restarts the walk from the lowest enabled channel and clears the accumulators and the pass count. The status registers keep their values.
- R10: Mode encodings are 0 = halted (no requests), 1 = one pass and then stop, 2 = continuous, and 3 = continuous with the fixed 16-sample window.
- R11: With no channel enabled, the block issues no request and no `eoc` or `eos`.
- R12: After reset, all status registers read zero and `conv_start`, `eoc` and `eos` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | One-cycle strobe that writes the mode and restarts the walk |
| mode_wdata | input | 2 | Mode value written by `mode_wr` |
| chan_en | input | 16 | Per-channel participation bits |
| settle_ext | input | 16 | Per-channel long-settling select |
| avg_en | input | 16 | Per-channel averaging enable |
| avg_sel | input | 2 | Averaging window select |
| conv_start | output | 1 | Conversion request pulse |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| mux_addr | output | 5 | Channel address for the external multiplexer |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-pass pulse |
| rd_addr | input | 5 | Status register read index |
| rd_data | output | 16 | Status register contents, result in bits 15:4 |

## Verification
The assertions check, on every cycle, that a request is a single-cycle pulse and that the address is unchanged when a request is made. They also check that every `eoc` follows a `conv_done`, that `eos` never appears without `eoc`, that every status write is followed by `eoc`, that a mode write suppresses a request in the next cycle, and that nothing is requested while halted. Only the bench scenarios can show the averaged values for each window size, the suppression of writes before a window closes, the settling counts, the visiting order across wrap and restart, and the retention of status across mode writes.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  localparam int PASS_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_REQ, ST_WAIT, ST_HALT} seq_state_e;
  typedef enum logic [1:0] {MD_HALT = 2'd0, MD_ONCE = 2'd1, MD_LOOP = 2'd2, MD_FIXED = 2'd3} seq_mode_e;

  // log2 of the averaging window
  function automatic logic [3:0] avg_shift(input logic [1:0] sel, input logic fixed16);
    logic [3:0] s;
    if (fixed16) s = 4'd4;
    else begin
      case (sel)
        2'd0:    s = 4'd0;
        2'd1:    s = 4'd4;
        2'd2:    s = 4'd6;
        default: s = 4'd8;
      endcase
    end
    return s;
  endfunction

  // index of the last pass of a window
  function automatic logic [PASS_W-1:0] avg_last_pass(input logic [3:0] shift);
    logic [PASS_W:0] lim;
    lim = ((PASS_W+1)'(1) << shift) - (PASS_W+1)'(1);
    return lim[PASS_W-1:0];
  endfunction
endpackage

// File: rtl/ch_picker.sv
module ch_picker #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W:0]     lo,
  output logic              found,
  output logic [CH_W-1:0]   idx
);
  // lowest set bit at or above lo
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(lo))) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/avg_bank.sv
module avg_bank #(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  parameter int REG_W  = 16,
  parameter int ACC_W  = 20,
  parameter int ADDR_W = 5,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PAD   = REG_W - RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic [RES_W-1:0]  smp_val,
  input  logic              avg_on,
  input  logic              last_pass,
  input  logic [3:0]        shift,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              stat_we
);
  logic [ACC_W-1:0] acc  [NUM_CH];
  logic [RES_W-1:0] stat [NUM_CH];
  logic [ACC_W-1:0] sum;
  logic [RES_W-1:0] wr_val;

  assign sum     = acc[smp_ch] + ACC_W'(smp_val);
  assign stat_we = smp_vld && (!avg_on || last_pass);
  assign wr_val  = avg_on ? RES_W'(sum >> shift) : smp_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        acc[i]  <= '0;
        stat[i] <= '0;
      end
    end else begin
      if (clr) begin
        for (int i = 0; i < NUM_CH; i++) acc[i] <= '0;
      end else if (smp_vld && avg_on) begin
        acc[smp_ch] <= last_pass ? '0 : sum;
      end
      if (stat_we) stat[smp_ch] <= wr_val;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NUM_CH)) rd_data = {stat[rd_addr[CH_W-1:0]], {PAD{1'b0}}};
  end
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer
  import chan_seq_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int RES_W       = 12,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 5,
  parameter int SETTLE_BASE = 4,
  parameter int SETTLE_EXT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] settle_ext,
  input  logic [NUM_CH-1:0] avg_en,
  input  logic [1:0]        avg_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              eoc,
  output logic              eos,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int ACC_W = RES_W + PASS_W;
  localparam int CNT_W = $clog2(SETTLE_EXT + 1);

  seq_state_e        state;
  seq_mode_e         mode_q;
  logic [CH_W-1:0]   cur_ch;
  logic [CNT_W-1:0]  settle_cnt, settle_len;
  logic [PASS_W-1:0] pass_cnt;
  logic              eoc_q, eos_q;

  // named internal events, also used by the checker
  logic              first_found, nxt_found;
  logic [CH_W-1:0]   first_idx, nxt_idx;
  logic              done_now, pass_end, last_pass, stat_we;
  logic [3:0]        shift;
  logic [1:0]        mode_now;

  ch_picker #(.NUM_CH(NUM_CH)) u_first (
    .mask(chan_en), .lo('0), .found(first_found), .idx(first_idx));
  ch_picker #(.NUM_CH(NUM_CH)) u_next (
    .mask(chan_en), .lo((CH_W+1)'(cur_ch) + (CH_W+1)'(1)),
    .found(nxt_found), .idx(nxt_idx));

  assign shift      = avg_shift(avg_sel, mode_q == MD_FIXED);
  assign last_pass  = (pass_cnt == avg_last_pass(shift));
  assign settle_len = settle_ext[cur_ch] ? CNT_W'(SETTLE_EXT) : CNT_W'(SETTLE_BASE);
  assign done_now   = (state == ST_WAIT) && conv_done && !mode_wr;
  assign pass_end   = done_now && !nxt_found;
  assign conv_start = (state == ST_REQ);
  assign mux_addr   = ADDR_W'(cur_ch);
  assign eoc        = eoc_q;
  assign eos        = eos_q;
  assign mode_now   = mode_q;

  avg_bank #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .REG_W(REG_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .smp_vld(done_now), .smp_ch(cur_ch),
    .smp_val(conv_result), .avg_on(avg_en[cur_ch]), .last_pass(last_pass),
    .shift(shift), .rd_addr(rd_addr), .rd_data(rd_data), .stat_we(stat_we));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= MD_HALT;
      cur_ch     <= '0;
      settle_cnt <= '0;
      pass_cnt   <= '0;
      eoc_q      <= 1'b0;
      eos_q      <= 1'b0;
    end else begin
      eoc_q <= done_now;
      eos_q <= pass_end;
      if (mode_wr) begin
        mode_q     <= seq_mode_e'(mode_wdata);
        state      <= ST_IDLE;
        cur_ch     <= '0;
        settle_cnt <= '0;
        pass_cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (mode_q != MD_HALT && first_found) begin
              cur_ch     <= first_idx;
              settle_cnt <= '0;
              state      <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            if (settle_cnt == settle_len - CNT_W'(1)) state <= ST_REQ;
            else settle_cnt <= settle_cnt + CNT_W'(1);
          end
          ST_REQ: state <= ST_WAIT;
          ST_WAIT: begin
            if (conv_done) begin
              settle_cnt <= '0;
              if (nxt_found) begin
                cur_ch <= nxt_idx;
                state  <= ST_SETTLE;
              end else begin
                pass_cnt <= last_pass ? '0 : pass_cnt + PASS_W'(1);
                if (mode_q == MD_ONCE) state <= ST_HALT;
                else if (first_found) begin
                  cur_ch <= first_idx;
                  state  <= ST_SETTLE;
                end else state <= ST_IDLE;
              end
            end
          end
          ST_HALT: state <= ST_HALT;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chan_sequencer_chk.sv
module chan_sequencer_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic              conv_start,
  input logic              conv_done,
  input logic [ADDR_W-1:0] mux_addr,
  input logic              eoc,
  input logic              eos,
  input logic              stat_we,
  input logic [1:0]        mode_now
);
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $stable(mux_addr));

  p_eoc_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(conv_done));

  p_write_flags_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> eoc);

  p_eos_with_eoc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> eoc);

  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !conv_start);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'd0) |-> !conv_start);
endmodule

bind chan_sequencer chan_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .conv_start(conv_start),
  .conv_done(conv_done), .mux_addr(mux_addr), .eoc(eoc), .eos(eos),
  .stat_we(stat_we), .mode_now(mode_now));

// File: tb/tb_chan_sequencer.sv
module tb_chan_sequencer;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = '0;
  logic [15:0] en_r = '0, ext_r = '0, avg_r = '0;
  logic [1:0]  sel_r = '0;
  logic        conv_start, conv_done, eoc, eos;
  logic [11:0] conv_result;
  logic [4:0]  mux_addr, rd_addr;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  chan_sequencer dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .chan_en(en_r), .settle_ext(ext_r), .avg_en(avg_r), .avg_sel(sel_r),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .mux_addr(mux_addr), .eoc(eoc), .eos(eos), .rd_addr(rd_addr), .rd_data(rd_data));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sample_of(input int ch, input int k);
    return 12'(ch * 200 + k * 3);
  endfunction
  function automatic int lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction
  function automatic int highest(input logic [15:0] m);
    for (int i = 15; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction
  function automatic int after(input logic [15:0] m, input int p);
    for (int i = p + 1; i < 16; i++) if (m[i]) return i;
    return lowest(m);
  endfunction

  // converter model: fixed latency, per-channel sample index
  int  nk [16];
  bit  busy = 0;
  int  lat = 0;
  int  mch = 0;
  initial begin conv_done = 1'b0; conv_result = '0; end
  always @(posedge clk) begin
    if (mode_wr) begin
      busy <= 0; conv_done <= 1'b0;
      for (int i = 0; i < 16; i++) nk[i] <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start && !busy) begin
        busy <= 1; lat <= LAT; mch <= int'(mux_addr);
      end else if (busy) begin
        if (lat == 1) begin
          conv_done   <= 1'b1;
          conv_result <= sample_of(mch, nk[mch]);
          nk[mch]     <= nk[mch] + 1;
          busy        <= 0;
        end else lat <= lat - 1;
      end
    end
  end

  // monitor, sampling at the falling edge
  int eoc_cnt = 0, eos_cnt = 0, start_cnt = 0, eoc_at_eos = 0, gap = 0;
  int prev = 0, first_ch = -1;
  bit armed = 0, prev_ok = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mode_wr) begin
        eoc_cnt = 0; eos_cnt = 0; start_cnt = 0; armed = 0; prev_ok = 0; first_ch = -1;
      end else begin
        if (conv_done) begin
          armed = 1; gap = 0;
        end else if (conv_start) begin
          chk("R1 visiting order", int'(mux_addr), prev_ok ? after(en_r, prev) : lowest(en_r));
          if (armed) chk("R2 settling cycles", gap, ext_r[mux_addr] ? 10 : 4);
          armed = 0; prev = int'(mux_addr); prev_ok = 1;
          if (start_cnt == 0) first_ch = int'(mux_addr);
          start_cnt++;
        end else if (armed) gap++;
        if (eoc) eoc_cnt++;
        if (eos) begin
          chk("R8 eos with eoc", int'(eoc), 1);
          chk("R8 eos on highest channel", prev, highest(en_r));
          eos_cnt++;
          eoc_at_eos = eoc_cnt;
        end
      end
    end
  end

  task automatic write_mode(input logic [1:0] m);
    @(posedge clk); #1;
    mode_wr = 1'b1; mode_wdata = m;
    @(posedge clk); #1;
    mode_wr = 1'b0;
  endtask

  task automatic setup(input logic [15:0] e, x, a, input logic [1:0] s, input logic [1:0] m);
    write_mode(2'd0);
    repeat (20) @(posedge clk);
    #1; en_r = e; ext_r = x; avg_r = a; sel_r = s;
    write_mode(m);
  endtask

  task automatic read_chk(input string req, input int ch, input int exp16);
    rd_addr = 5'(ch);
    #1;
    chk(req, int'(rd_data), exp16);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] en, ext, avgm;
    logic [1:0]  sel;
    logic [15:0] passes;
    logic [3:0]  ch;
    logic [11:0] exp;
    logic        pre;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd2, 16'h0013, 16'h0010, 16'h0000, 2'd0, 16'd3,  4'd4, 12'd806,  1'b0}, // R4
    '{2'd2, 16'h8201, 16'h8000, 16'h0200, 2'd1, 16'd16, 4'd9, 12'd1822, 1'b1}, // R5 16
    '{2'd3, 16'h0060, 16'h0040, 16'h0040, 2'd2, 16'd16, 4'd6, 12'd1222, 1'b1}, // R6
    '{2'd1, 16'h0108, 16'h0000, 16'h0000, 2'd0, 16'd1,  4'd8, 12'd1600, 1'b0}, // R10 once
    '{2'd2, 16'h0004, 16'h0000, 16'h0004, 2'd2, 16'd64, 4'd2, 12'd494,  1'b1}, // R5 64
    '{2'd2, 16'h0004, 16'h0004, 16'h0004, 2'd0, 16'd2,  4'd2, 12'd403,  1'b0}  // R5 window 1
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rd_addr = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 conv_start low", int'(conv_start), 0);
    chk("R12 eoc low", int'(eoc), 0);
    chk("R12 eos low", int'(eos), 0);
    begin
      int nz = 0;
      for (int c = 0; c < 16; c++) begin
        rd_addr = 5'(c); #1;
        if (rd_data != 0) nz++;
      end
      chk("R12 status cleared", nz, 0);
    end

    for (int v = 0; v < 6; v++) begin
      vec_t t;
      t = VECS[v];
      setup(t.en, t.ext, t.avgm, t.sel, t.mode);
      if (t.pre) begin
        wait (eos_cnt == int'(t.passes) - 1);
        read_chk("R5 no write before window ends", int'(t.ch), 0);
      end
      wait (eos_cnt == int'(t.passes));
      read_chk("R4/R5 status value", int'(t.ch), int'(t.exp) << 4);
      chk("R7 eoc per pass", eoc_at_eos, int'(t.passes) * $countones(t.en));
      if (t.mode == 2'd1) begin
        repeat (100) @(posedge clk);
        chk("R10 single pass stops", eoc_cnt, $countones(t.en));
      end
    end

    // R11 nothing enabled
    setup(16'h0000, 16'h0000, 16'h0000, 2'd0, 2'd2);
    repeat (200) @(posedge clk);
    chk("R11 no requests", start_cnt, 0);
    chk("R11 no eoc", eoc_cnt, 0);
    chk("R11 no eos", eos_cnt, 0);

    // R10 halt mode
    setup(16'h0003, 16'h0000, 16'h0000, 2'd0, 2'd0);
    repeat (100) @(posedge clk);
    chk("R10 halted no requests", start_cnt, 0);

    // R9 restart mid-pass, status retained
    setup(16'h00F0, 16'h0000, 16'h0000, 2'd0, 2'd2);
    wait (start_cnt == 3);
    write_mode(2'd2);
    wait (start_cnt == 1);
    chk("R9 restart from lowest", first_ch, 4);
    read_chk("R9 status kept", 9, 1822 << 4);

    // R9 accumulators cleared by a restart
    setup(16'h0004, 16'h0000, 16'h0004, 2'd1, 2'd2);
    wait (eos_cnt == 5);
    write_mode(2'd2);
    wait (eos_cnt == 16);
    read_chk("R9 accumulator cleared", 2, 422 << 4);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule